// File: doc/BRIEF.md
# Clocked Video Lock Gate

This block sits behind a clocked video receiver. It takes pixel samples with horizontal sync, vertical sync and a data-enable strobe, and it measures the incoming raster all the time: lines carrying picture, lines in total, samples per picture line, and how many frames in a row have repeated the same format. It can also tell whether the sync pulses are active high or active low, and it raises a flag when the total line count keeps changing by one line from frame to frame, which is the pattern of interlaced fields.

A small register port configures the block. Software writes the format it expects, using any mix of active lines, total lines, line width and a minimum run of stable frames, and then sets the enable bit. The gate opens a pixel output only when the block is enabled and every non-zero expected value agrees with the measurement. The gate changes state only at the start of a frame, so downstream logic always receives whole frames that begin with a start-of-frame marker. Measurement keeps running while the output is shut, so software can read the format of an unknown source before it lets the video through.

Top module: `vid_lock_gate`

## Requirements
- R1: While control bit 0 (enable) is 0, `pix_valid` stays 0. Measurement keeps running and its registers keep updating.
- R2: At each rising edge of the active-level vertical sync, the block latches the frame just ended into register 2 (total lines in [31:16], lines with at least one data-enable sample in [15:0]) and into register 3 [15:0] (the data-enable count of the last line of that frame that had any). A line ends at each rising edge of the active-level horizontal sync.
- R3: Register 3 [31:16] counts the frames in a row with identical active lines, total lines and width. It restarts at 1 on a change and reads 0 after a frame with no lines.
- R4: Register 4 holds the expected total lines in [31:16] and the expected active lines in [15:0]. A non-zero field must equal its measurement for output to be allowed. A zero field is ignored.
- R5: Register 5 holds the minimum stable-frame count in [31:16] and the expected width in [15:0]. Output needs the measured count to be at least the first and the measured width to equal the second. Zero fields are ignored.
- R6: If registers 4 and 5 are both zero, the first frame that starts after enable is set is passed whole.
- R7: Output starts only at a frame start where enable and match both hold. From there on, every data-enable sample of that frame appears on `pix_data` with `pix_valid` one cycle after its input. Status register 1 bit 4 reads 1 while frames are passed.
- R8: Clearing enable in the middle of a frame lets that frame finish. The next frame is not passed, and status bit 4 returns to 0.
- R9: With control bit 4 set, the sync level that lasts the shorter time is taken as the active level. Status bit 0 reports an inverted horizontal sync and status bit 1 an inverted vertical sync. With control bit 4 clear, both syncs are taken as active high and both status bits read 0.
- R10: Status bit 2 reads 1 when control bits [23:16] are non-zero and at least that many frame starts in a row have seen the total line count differ by exactly one from the previous frame. It reads 0 when those bits are zero.
- R11: The control register (address 0) stores bits 0, 3, 4 and [23:16] and reads back all other bits as 0. Bit 3 has no further effect.
- R12: `pix_sof` is 1 on the first valid sample of each passed frame and 0 on all others.
- R13: After reset all registers read 0 and `pix_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vid_data | input | DATA_W | Incoming pixel sample |
| vid_hs | input | 1 | Incoming horizontal sync, either polarity |
| vid_vs | input | 1 | Incoming vertical sync, either polarity |
| vid_de | input | 1 | Incoming data-enable |
| pix_data | output | DATA_W | Outgoing pixel sample |
| pix_valid | output | 1 | Outgoing sample is valid |
| pix_sof | output | 1 | First sample of a passed frame |
| pix_ready | input | 1 | Sink is able to take a sample; it must be 1 whenever `pix_valid` is 1 |
| csr_addr | input | 3 | Register address |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Data of the register addressed in the previous cycle |

## Verification
The bench builds the block with a 12-bit sample, 10-bit line counters and 12-bit sync run counters. At those sizes a frame is only 8 to 10 lines of 16 clocks, so dozens of whole frames fit into a short run. That makes multi-frame behaviour cheap to reach: the stable-frame threshold being crossed, a stop that waits out the current frame, interlace runs, and polarity settling after a switch to inverted syncs. The 12-bit run counters still saturate well above the longest sync level, so the comparison of level durations is never clipped.

// File: rtl/vlg_pkg.sv
`timescale 1ns/1ps
package vlg_pkg;
   // register addresses
   localparam logic [2:0] ADR_CTRL   = 3'd0;
   localparam logic [2:0] ADR_STAT   = 3'd1;
   localparam logic [2:0] ADR_MEAS_A = 3'd2;
   localparam logic [2:0] ADR_MEAS_B = 3'd3;
   localparam logic [2:0] ADR_REF_A  = 3'd4;
   localparam logic [2:0] ADR_REF_B  = 3'd5;

   typedef enum logic {G_HOLD = 1'b0, G_PASS = 1'b1} gate_st_e;

   // one frame's format, each field 16 bits wide
   typedef struct packed {
      logic [15:0] frm;
      logic [15:0] tot;
      logic [15:0] act;
      logic [15:0] wid;
   } fmt_s;
endpackage

// File: rtl/vlg_poldet.sv
`timescale 1ns/1ps
// Remembers how long each level of a sync line lasted; the shorter one is active.
module vlg_poldet #(
   parameter int RUN_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_raw,
   input  logic auto_en,
   output logic inv
);
   localparam logic [RUN_W-1:0] RUN_MAX = '1;

   logic             lvl_q;
   logic [RUN_W-1:0] run_q, len_hi_q, len_lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q    <= 1'b0;
         run_q    <= '0;
         len_hi_q <= '0;
         len_lo_q <= '0;
      end else begin
         lvl_q <= sync_raw;
         if (sync_raw != lvl_q) begin
            if (lvl_q) len_hi_q <= run_q;
            else       len_lo_q <= run_q;
            run_q <= RUN_W'(1);
         end else if (run_q != RUN_MAX) begin
            run_q <= run_q + RUN_W'(1);
         end
      end
   end

   assign inv = auto_en && (len_hi_q > len_lo_q);
endmodule

// File: rtl/vlg_measure.sv
`timescale 1ns/1ps
module vlg_measure import vlg_pkg::*; #(
   parameter int LINE_W = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hs_a,
   input  logic       vs_a,
   input  logic       de,
   input  logic [7:0] ilace_min,
   output fmt_s       meas,
   output logic       frm_tick,
   output logic       ilace
);
   localparam logic [LINE_W-1:0] L_ONE   = LINE_W'(1);
   localparam logic [15:0]       FRM_MAX = '1;
   localparam logic [7:0]        ALT_MAX = '1;

   logic              hs_q, vs_q, hs_start, vs_start, line_de, same, step1;
   logic [LINE_W-1:0] tot_c, act_c, wid_c, wid_hold;
   logic [LINE_W-1:0] m_tot, m_act, m_wid;
   logic [LINE_W-1:0] nxt_tot, nxt_act, nxt_wid;
   logic [15:0]       m_frm;
   logic [7:0]        alt_c;

   always_comb begin
      hs_start = hs_a & ~hs_q;
      vs_start = vs_a & ~vs_q;
      nxt_tot  = tot_c + (hs_start ? L_ONE : '0);
      nxt_act  = act_c + ((hs_start && line_de) ? L_ONE : '0);
      nxt_wid  = (hs_start && wid_c != '0) ? wid_c : wid_hold;
      same     = (nxt_tot == m_tot) && (nxt_act == m_act) && (nxt_wid == m_wid);
      step1    = (nxt_tot != '0) &&
                 ((nxt_tot == m_tot + L_ONE) || (m_tot == nxt_tot + L_ONE));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_q <= 1'b0;  vs_q <= 1'b0;  line_de <= 1'b0;  frm_tick <= 1'b0;
         tot_c <= '0;  act_c <= '0;  wid_c <= '0;  wid_hold <= '0;
         m_tot <= '0;  m_act <= '0;  m_wid <= '0;  m_frm <= '0;  alt_c <= '0;
      end else begin
         hs_q     <= hs_a;
         vs_q     <= vs_a;
         frm_tick <= vs_start;
         if (vs_start) begin
            m_tot <= nxt_tot;
            m_act <= nxt_act;
            m_wid <= nxt_wid;
            if (nxt_tot == '0)       m_frm <= '0;
            else if (!same)          m_frm <= 16'd1;
            else if (m_frm != FRM_MAX) m_frm <= m_frm + 16'd1;
            if (!step1)              alt_c <= '0;
            else if (alt_c != ALT_MAX) alt_c <= alt_c + 8'd1;
            tot_c    <= '0;
            act_c    <= '0;
            wid_hold <= '0;
            wid_c    <= de ? L_ONE : '0;
            line_de  <= de;
         end else begin
            tot_c <= nxt_tot;
            act_c <= nxt_act;
            if (hs_start) begin
               wid_hold <= nxt_wid;
               wid_c    <= de ? L_ONE : '0;
               line_de  <= de;
            end else begin
               wid_c   <= wid_c + (de ? L_ONE : '0);
               line_de <= line_de | de;
            end
         end
      end
   end

   always_comb begin
      meas.tot = 16'(m_tot);
      meas.act = 16'(m_act);
      meas.wid = 16'(m_wid);
      meas.frm = m_frm;
   end

   assign ilace = (ilace_min != 8'd0) && (alt_c >= ilace_min);

   AST_ACT_LE_TOT: assert property (@(posedge clk) disable iff (!rst_n)
      frm_tick |-> (meas.act <= meas.tot)); // R2
   AST_MEAS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_tick |-> $stable(meas)); // R2
   AST_EMPTY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_tick && meas.tot == 16'd0) |-> (meas.frm == 16'd0)); // R3
endmodule

// File: rtl/vlg_gate.sv
`timescale 1ns/1ps
module vlg_gate import vlg_pkg::*; (
   input  logic clk,
   input  logic rst_n,
   input  logic frm_tick,
   input  logic enable,
   input  logic match,
   input  logic de_d,
   output logic streaming,
   output logic pix_valid,
   output logic pix_sof
);
   gate_st_e st_q;
   logic     sof_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= G_HOLD;
         sof_pend <= 1'b0;
      end else if (frm_tick) begin
         st_q     <= (enable && match) ? G_PASS : G_HOLD;
         sof_pend <= 1'b1;
      end else if (pix_valid) begin
         sof_pend <= 1'b0;
      end
   end

   assign streaming = (st_q == G_PASS);
   assign pix_valid = streaming && de_d;
   assign pix_sof   = pix_valid && sof_pend;

   AST_START_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(streaming) |-> $past(frm_tick)); // R7
   AST_STOP_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(streaming) |-> $past(frm_tick)); // R8
   AST_SHUT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_tick && !enable) |=> !streaming); // R1
   AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_sof && !frm_tick) |=> !pix_sof); // R12
endmodule

// File: rtl/vlg_regs.sv
`timescale 1ns/1ps
module vlg_regs import vlg_pkg::*; (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  csr_addr,
   input  logic        csr_wr,
   input  logic [31:0] csr_wdata,
   output logic [31:0] csr_rdata,
   input  fmt_s        meas,
   input  logic        streaming,
   input  logic [1:0]  sync_inv,
   input  logic        ilace,
   output logic        enable,
   output logic        auto_pol,
   output logic [7:0]  ilace_min,
   output fmt_s        ref_fmt
);
   logic        clean_q;
   logic [31:0] ref_a_q, ref_b_q, rd_nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable <= 1'b0;  clean_q <= 1'b0;  auto_pol <= 1'b0;  ilace_min <= '0;
         ref_a_q <= '0;   ref_b_q <= '0;
      end else if (csr_wr) begin
         case (csr_addr)
            ADR_CTRL: begin
               enable    <= csr_wdata[0];
               clean_q   <= csr_wdata[3];
               auto_pol  <= csr_wdata[4];
               ilace_min <= csr_wdata[23:16];
            end
            ADR_REF_A: ref_a_q <= csr_wdata;
            ADR_REF_B: ref_b_q <= csr_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (csr_addr)
         ADR_CTRL:   rd_nxt = {8'd0, ilace_min, 11'd0, auto_pol, clean_q, 2'd0, enable};
         ADR_STAT:   rd_nxt = {27'd0, streaming, 1'b0, ilace, sync_inv};
         ADR_MEAS_A: rd_nxt = {meas.tot, meas.act};
         ADR_MEAS_B: rd_nxt = {meas.frm, meas.wid};
         ADR_REF_A:  rd_nxt = ref_a_q;
         ADR_REF_B:  rd_nxt = ref_b_q;
         default:    rd_nxt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) csr_rdata <= '0;
      else        csr_rdata <= rd_nxt;
   end

   always_comb begin
      ref_fmt.tot = ref_a_q[31:16];
      ref_fmt.act = ref_a_q[15:0];
      ref_fmt.frm = ref_b_q[31:16];
      ref_fmt.wid = ref_b_q[15:0];
   end

   AST_CTRL_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(csr_wr && csr_addr == ADR_CTRL) |-> (enable == $past(csr_wdata[0]))); // R11
endmodule

// File: rtl/vid_lock_gate.sv
`timescale 1ns/1ps
module vid_lock_gate import vlg_pkg::*; #(
   parameter int DATA_W     = 24,
   parameter int LINE_W     = 12,
   parameter int RUN_W      = 16,
   parameter bit POL_DETECT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] vid_data,
   input  logic              vid_hs,
   input  logic              vid_vs,
   input  logic              vid_de,
   output logic [DATA_W-1:0] pix_data,
   output logic              pix_valid,
   output logic              pix_sof,
   input  logic              pix_ready,
   input  logic [2:0]        csr_addr,
   input  logic              csr_wr,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata
);
   if (DATA_W < 1)                 begin : g_bad_data $error("DATA_W must be positive"); end
   if (LINE_W < 2 || LINE_W > 16)  begin : g_bad_line $error("LINE_W must be 2..16"); end
   if (RUN_W < 4)                  begin : g_bad_run  $error("RUN_W must be at least 4"); end

   logic [1:0]        sync_raw, sync_inv;
   logic              enable, auto_pol, frm_tick, ilace, match, streaming, de_d;
   logic [7:0]        ilace_min;
   logic [DATA_W-1:0] dat_d;
   fmt_s              meas, ref_fmt;

   assign sync_raw = {vid_vs, vid_hs};

   if (POL_DETECT) begin : g_pol
      for (genvar i = 0; i < 2; i++) begin : g_ch
         vlg_poldet #(.RUN_W(RUN_W)) u_det (
            .clk(clk), .rst_n(rst_n), .sync_raw(sync_raw[i]),
            .auto_en(auto_pol), .inv(sync_inv[i]));
      end
   end else begin : g_nopol
      assign sync_inv = 2'b00;
   end

   vlg_measure #(.LINE_W(LINE_W)) u_meas (
      .clk(clk), .rst_n(rst_n),
      .hs_a(vid_hs ^ sync_inv[0]), .vs_a(vid_vs ^ sync_inv[1]), .de(vid_de),
      .ilace_min(ilace_min), .meas(meas), .frm_tick(frm_tick), .ilace(ilace));

   always_comb begin
      match = ((ref_fmt.act == 16'd0) || (ref_fmt.act == meas.act)) &&
              ((ref_fmt.tot == 16'd0) || (ref_fmt.tot == meas.tot)) &&
              ((ref_fmt.wid == 16'd0) || (ref_fmt.wid == meas.wid)) &&
              ((ref_fmt.frm == 16'd0) || (meas.frm >= ref_fmt.frm));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dat_d <= '0;
         de_d  <= 1'b0;
      end else begin
         dat_d <= vid_data;
         de_d  <= vid_de;
      end
   end

   vlg_gate u_gate (
      .clk(clk), .rst_n(rst_n), .frm_tick(frm_tick), .enable(enable), .match(match),
      .de_d(de_d), .streaming(streaming), .pix_valid(pix_valid), .pix_sof(pix_sof));

   assign pix_data = dat_d;

   vlg_regs u_regs (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .meas(meas),
      .streaming(streaming), .sync_inv(sync_inv), .ilace(ilace),
      .enable(enable), .auto_pol(auto_pol), .ilace_min(ilace_min), .ref_fmt(ref_fmt));

   AST_SINK_READY: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> pix_ready); // R7
   AST_NO_OUT_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !pix_valid); // R13
endmodule

// File: tb/vid_lock_gate_tb.sv
`timescale 1ns/1ps
module vid_lock_gate_tb;
   localparam int DW = 12;
   localparam int LEN = 16;   // clocks per line

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] vid_data = '0;
   logic          vid_hs = 1'b0, vid_vs = 1'b0, vid_de = 1'b0;
   logic [DW-1:0] pix_data;
   logic          pix_valid, pix_sof;
   logic          pix_ready = 1'b1;
   logic [2:0]    csr_addr = '0;
   logic          csr_wr = 1'b0;
   logic [31:0]   csr_wdata = '0;
   logic [31:0]   csr_rdata;

   int    n_chk = 0, n_fail = 0;
   string cur_req = "R13";
   logic [DW:0] exp_q[$];   // {sof, data}

   always #10 clk = ~clk;

   vid_lock_gate #(.DATA_W(DW), .LINE_W(10), .RUN_W(12), .POL_DETECT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .vid_data(vid_data), .vid_hs(vid_hs), .vid_vs(vid_vs),
      .vid_de(vid_de), .pix_data(pix_data), .pix_valid(pix_valid), .pix_sof(pix_sof),
      .pix_ready(pix_ready), .csr_addr(csr_addr), .csr_wr(csr_wr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
      @(negedge clk);
      csr_wr = 1'b0;
   endtask

   task automatic csr_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      csr_addr = a;
      @(negedge clk);
      d = csr_rdata;
   endtask

   task automatic idle(input int n, input bit inv);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         vid_hs = inv; vid_vs = inv; vid_de = 1'b0; vid_data = '0;
      end
   endtask

   // lines of LEN clocks: hsync 2, back porch 2, picture w, rest blank;
   // vsync covers line 0; picture lines are 2 .. 2+a-1
   task automatic send_frame(input int l, input int a, input int w, input bit inv,
                             input bit push, input int base);
      bit first = 1'b1;
      for (int ln = 0; ln < l; ln++) begin
         for (int c = 0; c < LEN; c++) begin
            logic d;
            @(negedge clk);
            d = (ln >= 2) && (ln < 2 + a) && (c >= 4) && (c < 4 + w);
            vid_hs   = (c < 2) ^ inv;
            vid_vs   = (ln == 0) ^ inv;
            vid_de   = d;
            vid_data = d ? DW'(base + ln * LEN + c) : '0;
            if (d && push) begin
               exp_q.push_back({first, DW'(base + ln * LEN + c)});
               first = 1'b0;
            end
         end
      end
   endtask

   task automatic drain_check(input string req);
      idle(8, 1'b0);
      check(req, 32'(exp_q.size()), 32'd0);
      exp_q.delete();
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && pix_valid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL %s actual=unexpected sample %h expected=no output", cur_req, pix_data);
         end else begin
            logic [DW:0] e;
            e = exp_q.pop_front();
            check({cur_req, "/R12"}, {19'd0, pix_sof, pix_data}, {19'd0, e});
         end
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R13 reset state
      check("R13 valid", {31'd0, pix_valid}, 32'd0);
      csr_read(3'd0, v); check("R13 ctrl", v, 32'd0);
      csr_read(3'd1, v); check("R13 status", v, 32'd0);
      csr_read(3'd2, v); check("R13 meas", v, 32'd0);

      // R1: disabled, measurement still runs
      cur_req = "R1";
      for (int k = 0; k < 3; k++) send_frame(8, 4, 6, 1'b0, 1'b0, 16 * k);
      idle(20, 1'b0);
      check("R1 no output", 32'(exp_q.size()), 32'd0);
      csr_read(3'd2, v); check("R2 lines", v, 32'h0008_0004);
      csr_read(3'd3, v); check("R3 frames/R2 width", v, 32'h0002_0006);
      csr_read(3'd1, v); check("R1 status", v, 32'd0);

      // R6: zero references, enable
      cur_req = "R6";
      csr_write(3'd0, 32'd1);
      send_frame(8, 4, 6, 1'b0, 1'b1, 200);
      send_frame(8, 4, 6, 1'b0, 1'b1, 400);
      drain_check("R6 all samples");
      csr_read(3'd1, v); check("R7 status streaming", v, 32'h10);

      // R8: disable mid-frame
      cur_req = "R8";
      fork
         send_frame(8, 4, 6, 1'b0, 1'b1, 600);
         begin repeat (60) @(negedge clk); csr_write(3'd0, 32'd0); end
      join
      send_frame(8, 4, 6, 1'b0, 1'b0, 800);
      drain_check("R8 frame finished");
      csr_read(3'd1, v); check("R8 status", v, 32'd0);

      // R4: active-line mismatch blocks output
      cur_req = "R4";
      csr_write(3'd4, 32'h0008_0005);
      csr_write(3'd0, 32'd1);
      send_frame(8, 4, 6, 1'b0, 1'b0, 1000);
      send_frame(8, 4, 6, 1'b0, 1'b0, 1200);
      send_frame(10, 4, 6, 1'b0, 1'b0, 1400);
      drain_check("R4 mismatch");
      csr_read(3'd1, v); check("R4 status", v, 32'd0);

      // R5: stable-frame threshold 3, width 6, active lines wildcard
      cur_req = "R5";
      csr_write(3'd4, 32'h0008_0000);
      csr_write(3'd5, 32'h0003_0006);
      send_frame(8, 4, 6, 1'b0, 1'b0, 1600);
      send_frame(8, 4, 6, 1'b0, 1'b0, 1800);
      send_frame(8, 4, 6, 1'b0, 1'b0, 2000);
      drain_check("R5 held");
      csr_read(3'd3, v); check("R3 count before", v, 32'h0002_0006);
      cur_req = "R7";
      send_frame(8, 4, 6, 1'b0, 1'b1, 2200);
      send_frame(8, 4, 6, 1'b0, 1'b1, 2400);
      drain_check("R7 start at boundary");
      csr_read(3'd1, v); check("R7 status", v, 32'h10);
      csr_write(3'd0, 32'd0);
      csr_write(3'd4, 32'd0);
      csr_write(3'd5, 32'd0);

      // R9: inverted syncs, automatic detection
      cur_req = "R9";
      idle(40, 1'b1);
      csr_write(3'd0, 32'h10);
      for (int k = 0; k < 4; k++) send_frame(8, 4, 6, 1'b1, 1'b0, 100 * k);
      idle(10, 1'b1);
      csr_read(3'd1, v); check("R9 inverted detected", v, 32'h3);
      csr_read(3'd2, v); check("R2 inverted lines", v, 32'h0008_0004);
      csr_write(3'd0, 32'h0);
      csr_read(3'd1, v); check("R9 detection off", v, 32'h0);
      drain_check("R9 no output");

      // R10: alternating line counts
      cur_req = "R10";
      idle(40, 1'b0);
      csr_write(3'd0, 32'h0002_0000);
      send_frame(8, 4, 6, 1'b0, 1'b0, 0);
      send_frame(9, 4, 6, 1'b0, 1'b0, 0);
      send_frame(8, 4, 6, 1'b0, 1'b0, 0);
      send_frame(9, 4, 6, 1'b0, 1'b0, 0);
      send_frame(8, 4, 6, 1'b0, 1'b0, 0);
      idle(10, 1'b0);
      csr_read(3'd1, v); check("R10 interlace flag", v, 32'h4);
      csr_write(3'd0, 32'h0);
      csr_read(3'd1, v); check("R10 disabled", v, 32'h0);

      // R11: control readback
      cur_req = "R11";
      csr_write(3'd0, 32'hFFFF_FFFF);
      csr_read(3'd0, v); check("R11 ctrl readback", v, 32'h00FF_0019);
      csr_write(3'd0, 32'h0000_0008);
      csr_read(3'd0, v); check("R11 cleaner bit", v, 32'h0000_0008);
      csr_read(3'd1, v); check("R11 cleaner no effect", v, 32'h0);
      drain_check("R11 no output");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule